// File: doc/BRIEF.md
# Serial Display Command and Read Transceiver

This block is a four-wire serial master for a small display controller that takes a separate data/command select line. The host hands it one request at a time: a command byte, a length, and whether the request writes parameters or reads a response. A write frame sends the command byte with the select line low and then the parameter bytes with it high. A read frame keeps the select line low, sends the command, and then clocks in the response bytes at a reduced bit rate.

Two read commands, display identification (0x04) and status (0x09), answer with one dummy clock ahead of the data. For these the block clocks in one extra byte and shifts the whole response left by one bit, so the host sees clean bytes. The block enforces the legal lengths for reads and rejects bad requests without touching the bus. It also decodes every power-mode readback (0x0A) into a flag that says whether the display is fully active.

The bit rates are fixed when the design is built, from the system clock frequency and the highest serial clock the display allows. Short transfers and command bytes run at a capped control rate. Long pixel payloads run at the full rate. Reads run at the slowest of the three rates.

Top module: `dbi_spi_xcvr`

## Requirements
- R1: A write frame holds cs_no low from the first serial clock to the last. It sends the command byte with dc_o=0 and then req_len_i parameter bytes, in the order they are taken from wr_data_i, with dc_o=1. Every byte goes out MSB first in serial mode 0: sck_o idles low, data is stable while sck_o is high, and the slave samples on the rising edge. A length of 0 sends only the command byte.
- R2: The command byte of a write, and the parameter bytes of a write with req_len_i at most 64, use a serial clock half period of CMD_HALF = max(ceil(CLK_HZ/(2*CMD_SCK_HZ)), ceil(CLK_HZ/(2*MAX_SCK_HZ))) system clocks. With the defaults this is 13.
- R3: The parameter bytes of a write with req_len_i above 64 use a half period of BULK_HALF = ceil(CLK_HZ/(2*MAX_SCK_HZ)). With the defaults this is 5.
- R4: A read frame keeps dc_o=0 for its whole length. It sends the command byte and then clocks req_len_i bytes in from miso_i while mosi_o carries zeros. Each byte is delivered on rd_data_o with a one-cycle rd_valid_o. All bits of the frame use READ_HALF = max(ceil(CLK_HZ/(2*RD_SCK_HZ)), 2*BULK_HALF). With the defaults this is 63.
- R5: A read of command 0x04 or 0x09 clocks in req_len_i+1 raw bytes. Output byte i equals (raw[i] << 1) | raw[i+1][7], so a response delayed by one dummy bit is delivered aligned.
- R6: A read of command 0x04 or 0x09 with a length other than 3 or 4 is rejected. The block raises done_o with err_o and never lowers cs_no.
- R7: A read with req_len_i = 0 is rejected in the same way.
- R8: Each byte delivered by a read of command 0x0A sets disp_on_o to 1 if (byte & 0x7C) == 0x1C, and to 0 otherwise. Bits 0, 1 and 7 are ignored. Other requests leave disp_on_o unchanged, and it resets to 0.
- R9: Every request, accepted or rejected, ends with a one-cycle done_o pulse. err_o is high only on the done_o pulse of a rejected request. req_ready_o is high only when no frame is in progress.
- R10: After reset, cs_no=1, sck_o=0, dc_o=0, done_o=0, err_o=0, disp_on_o=0 and req_ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when req_ready_o is high |
| req_ready_o | output | 1 | Idle, able to take a request |
| req_read_i | input | 1 | 1 for a read request, 0 for a write |
| req_cmd_i | input | 8 | Command byte |
| req_len_i | input | LEN_W | Number of parameter or response bytes |
| wr_data_i | input | 8 | Next write parameter byte |
| wr_pop_o | output | 1 | High in the cycle wr_data_i is taken |
| rd_data_o | output | 8 | Aligned response byte |
| rd_valid_o | output | 1 | rd_data_o valid for one cycle |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Request rejected, valid with done_o |
| disp_on_o | output | 1 | Last power-mode readback showed the display active |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |
| dc_o | output | 1 | Data/command select: 0 for command, 1 for parameters |

## Verification
Writes are sent with no parameters, with exactly 64 parameters and with 65 parameters. Each case compares every byte and its select level on the wire, and the serial clock high time, which separates the control rate from the bulk rate at the 64/65 boundary. Reads are tried with a plain command and with the identification and status commands at lengths 3 and 4. The slave model inserts a real dummy bit for the latter, so a missing or wrong realignment shows up as shifted bytes. Illegal read lengths must produce an error with no chip-select activity. Power-mode responses that differ only in the ignored bits, or in one significant bit, separate correct masking from a plain compare.

// File: rtl/dbi_xcvr_pkg.sv
package dbi_xcvr_pkg;
  localparam logic [7:0] CMD_RD_ID     = 8'h04;
  localparam logic [7:0] CMD_RD_STATUS = 8'h09;
  localparam logic [7:0] CMD_RD_PWR    = 8'h0A;
  localparam int         SMALL_XFER    = 64;
  localparam logic [7:0] PWR_MASK      = 8'h7C;
  localparam logic [7:0] PWR_ACTIVE    = 8'h1C;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA, ST_END} xcvr_state_t;
endpackage

// File: rtl/dbi_byte_shift.sv
// One byte, serial mode 0, MSB first, half period from half_i.
module dbi_byte_shift #(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [7:0]        tx_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [7:0]        rx_o,
  output logic              done_o
);
  logic              active_q;
  logic [HALF_W-1:0] cnt_q;
  logic [2:0]        bit_q;
  logic [7:0]        tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_o    <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        sck_o    <= 1'b0;
        cnt_q    <= '0;
        bit_q    <= '0;
        tx_q     <= tx_i;
      end else if (active_q) begin
        if (cnt_q == half_i - 1'b1) begin
          cnt_q <= '0;
          if (!sck_o) begin
            sck_o <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            sck_o <= 1'b0;
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_o   <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= tx_q << 1;
            end
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign mosi_o = tx_q[7];
  assign rx_o   = rx_q;
endmodule

// File: rtl/dbi_rx_align.sv
// Removes a one-bit dummy lead by combining adjacent raw bytes.
module dbi_rx_align (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       shift_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_byte_i,
  output logic       out_valid_o,
  output logic [7:0] out_byte_o
);
  logic [7:0] prev_q;
  logic       have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_q      <= 1'b0;
      out_valid_o <= 1'b0;
      out_byte_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (clear_i) begin
        have_q <= 1'b0;
      end else if (in_valid_i) begin
        if (!shift_i) begin
          out_byte_o  <= in_byte_i;
          out_valid_o <= 1'b1;
        end else begin
          prev_q <= in_byte_i;
          have_q <= 1'b1;
          if (have_q) begin
            out_byte_o  <= 8'({prev_q, in_byte_i} >> 7);
            out_valid_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dbi_pwr_eval.sv
module dbi_pwr_eval
  import dbi_xcvr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic [7:0] byte_i,
  output logic       on_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    on_o <= 1'b0;
    else if (upd_i) on_o <= ((byte_i & PWR_MASK) == PWR_ACTIVE);
  end
endmodule

// File: rtl/dbi_spi_xcvr.sv
module dbi_spi_xcvr
  import dbi_xcvr_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int MAX_SCK_HZ = 25_000_000,
  parameter int CMD_SCK_HZ = 10_000_000,
  parameter int RD_SCK_HZ  = 2_000_000,
  parameter int LEN_W      = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_read_i,
  input  logic [7:0]       req_cmd_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_pop_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             err_o,
  output logic             disp_on_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             cs_no,
  output logic             dc_o
);
  localparam int BULK_HALF = (CLK_HZ + 2*MAX_SCK_HZ - 1) / (2*MAX_SCK_HZ);
  localparam int CMD_LIM   = (CLK_HZ + 2*CMD_SCK_HZ - 1) / (2*CMD_SCK_HZ);
  localparam int RD_LIM    = (CLK_HZ + 2*RD_SCK_HZ - 1) / (2*RD_SCK_HZ);
  localparam int CMD_HALF  = (CMD_LIM > BULK_HALF) ? CMD_LIM : BULK_HALF;
  localparam int READ_HALF = (RD_LIM > 2*BULK_HALF) ? RD_LIM : 2*BULK_HALF;
  localparam int TOP_HALF  = (READ_HALF > CMD_HALF) ? READ_HALF : CMD_HALF;
  localparam int HALF_W    = $clog2(TOP_HALF + 1);

  xcvr_state_t       st_q;
  logic [LEN_W:0]    left_q;
  logic              is_rd_q, shift_q, is_pwr_q, big_q, clr_q;
  logic              sh_start_q, sh_done;
  logic [7:0]        sh_tx_q, sh_rx;
  logic [HALF_W-1:0] sh_half_q;
  logic              shift_cmd, bad_req, raw_valid;

  assign shift_cmd = (req_cmd_i == CMD_RD_ID) || (req_cmd_i == CMD_RD_STATUS);
  assign bad_req   = req_read_i && ((req_len_i == '0) ||
                     (shift_cmd && req_len_i != LEN_W'(3) && req_len_i != LEN_W'(4)));
  assign req_ready_o = (st_q == ST_IDLE);
  assign wr_pop_o  = !is_rd_q && sh_done && (left_q != '0) &&
                     ((st_q == ST_CMD) || (st_q == ST_DATA));
  assign raw_valid = is_rd_q && sh_done && (st_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      left_q     <= '0;
      is_rd_q    <= 1'b0;
      shift_q    <= 1'b0;
      is_pwr_q   <= 1'b0;
      big_q      <= 1'b0;
      clr_q      <= 1'b0;
      sh_start_q <= 1'b0;
      sh_tx_q    <= '0;
      sh_half_q  <= HALF_W'(CMD_HALF);
      cs_no      <= 1'b1;
      dc_o       <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      sh_start_q <= 1'b0;
      clr_q      <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          if (bad_req) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            is_rd_q    <= req_read_i;
            shift_q    <= req_read_i && shift_cmd;
            is_pwr_q   <= req_read_i && (req_cmd_i == CMD_RD_PWR);
            big_q      <= req_len_i > LEN_W'(SMALL_XFER);
            left_q     <= {1'b0, req_len_i} + (LEN_W+1)'(req_read_i && shift_cmd);
            sh_tx_q    <= req_cmd_i;
            sh_half_q  <= req_read_i ? HALF_W'(READ_HALF) : HALF_W'(CMD_HALF);
            sh_start_q <= 1'b1;
            clr_q      <= 1'b1;
            cs_no      <= 1'b0;
            dc_o       <= 1'b0;
            st_q       <= ST_CMD;
          end
        end
        ST_CMD, ST_DATA: if (sh_done) begin
          if (left_q == '0) begin
            st_q <= ST_END;
          end else begin
            sh_start_q <= 1'b1;
            left_q     <= left_q - 1'b1;
            sh_tx_q    <= is_rd_q ? 8'h00 : wr_data_i;
            if (st_q == ST_CMD && !is_rd_q) begin
              dc_o      <= 1'b1;
              sh_half_q <= big_q ? HALF_W'(BULK_HALF) : HALF_W'(CMD_HALF);
            end
            st_q <= ST_DATA;
          end
        end
        ST_END: begin
          cs_no  <= 1'b1;
          dc_o   <= 1'b0;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  dbi_byte_shift #(.HALF_W(HALF_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start_q),
    .half_i  (sh_half_q),
    .tx_i    (sh_tx_q),
    .miso_i  (miso_i),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .rx_o    (sh_rx),
    .done_o  (sh_done)
  );

  dbi_rx_align u_align (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clr_q),
    .shift_i     (shift_q),
    .in_valid_i  (raw_valid),
    .in_byte_i   (sh_rx),
    .out_valid_o (rd_valid_o),
    .out_byte_o  (rd_data_o)
  );

  dbi_pwr_eval u_pwr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (rd_valid_o && is_pwr_q),
    .byte_i (rd_data_o),
    .on_o   (disp_on_o)
  );
endmodule

// File: rtl/dbi_spi_xcvr_chk.sv
module dbi_spi_xcvr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sck_o,
  input logic mosi_o,
  input logic dc_o,
  input logic done_o,
  input logic err_o,
  input logic is_rd_q
);
  // R1
  dc_low_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !dc_o);
  // R1
  sck_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);
  // R1
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
  // R1
  dc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(dc_o));
  // R4
  read_dc_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd_q && !cs_no) |-> !dc_o);
  // R9
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  // R6
  reject_idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_no && $past(cs_no)));
endmodule

bind dbi_spi_xcvr dbi_spi_xcvr_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_no   (cs_no),
  .sck_o   (sck_o),
  .mosi_o  (mosi_o),
  .dc_o    (dc_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .is_rd_q (is_rd_q)
);

// File: tb/dbi_spi_xcvr_tb.sv
module dbi_spi_xcvr_tb;
  localparam int LEN_W  = 12;
  localparam int H_BULK = 5;   // ceil(250M / 50M)
  localparam int H_CMD  = 13;  // ceil(250M / 20M)
  localparam int H_RD   = 63;  // ceil(250M / 4M) > 2*5

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_read = 1'b0;
  logic [7:0] req_cmd = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] wr_data;
  logic req_ready, wr_pop, rd_valid, done, err, disp_on;
  logic sck, mosi, cs_n, dc;
  logic miso = 1'b0;
  logic [7:0] rd_data;

  logic [7:0] payload [0:127];
  logic [7:0] resp [0:7];
  bit   resp_dummy = 1'b0;
  int   wr_cnt = 0, wr_base = 0;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  logic [8:0] bus_q [$];
  logic [7:0] rd_q  [$];

  assign wr_data = payload[(wr_cnt - wr_base) & 127];
  always @(posedge clk) if (wr_pop) wr_cnt <= wr_cnt + 1;

  dbi_spi_xcvr #(.LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_read_i(req_read),
    .req_cmd_i(req_cmd), .req_len_i(req_len),
    .wr_data_i(wr_data), .wr_pop_o(wr_pop),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .done_o(done), .err_o(err), .disp_on_o(disp_on),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n), .dc_o(dc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Slave model and monitor: bus bytes, clock widths, response bits
  int sbit = 0, hi = 0, pcnt = 0, frames = 0, w_first = 0, w_last = 0;
  logic [7:0] sh = '0;
  logic sck_prev = 1'b0, cs_prev = 1'b1;
  always @(negedge clk) begin
    if (cs_n) begin
      sbit = 0; hi = 0; pcnt = 0; miso = 1'b0;
    end else begin
      if (cs_prev) frames++;
      if (sck && !sck_prev) begin
        sh = {sh[6:0], mosi};
        sbit++;
        if (sbit % 8 == 0) begin
          if (bus_q.size() == 0) chk(1'b0, "R1 unexpected bus byte", {dc, sh}, 0);
          else begin
            logic [8:0] e;
            e = bus_q.pop_front();
            chk({dc, sh} == e, "R1/R4 bus byte {dc,data}", {dc, sh}, e);
          end
        end
      end
      if (sck) hi++;
      if (!sck && sck_prev) begin
        int k, j;
        pcnt++;
        if (pcnt <= 8) w_first = hi; else w_last = hi;
        hi = 0;
        k = sbit - 8;
        if (k < 0) miso = 1'b0;
        else begin
          j = resp_dummy ? k - 1 : k;
          if (j < 0 || j >= 64) miso = 1'b0;
          else miso = resp[j/8][7 - (j%8)];
        end
      end
    end
    sck_prev = sck;
    cs_prev  = cs_n;
  end

  always @(negedge clk) if (rd_valid) begin
    if (rd_q.size() == 0) chk(1'b0, "R4 unexpected read byte", rd_data, 0);
    else begin
      logic [7:0] e;
      e = rd_q.pop_front();
      chk(rd_data == e, "R4/R5 read byte", rd_data, e);
    end
  end

  task automatic issue(input bit rd, input logic [7:0] cmd, input int len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_cmd = cmd; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic end_checks(input string tag);
    chk(err == 1'b0, {tag, " R9 err low on accepted"}, err, 0);
    chk(bus_q.size() == 0, {tag, " R1 all bus bytes seen"}, bus_q.size(), 0);
    chk(rd_q.size() == 0, {tag, " R4 all read bytes seen"}, rd_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
    chk(req_ready == 1'b1, {tag, " R9 ready after frame"}, req_ready, 1);
  endtask

  task automatic do_write(input logic [7:0] cmd, input int len, input string tag);
    wr_base = wr_cnt;
    bus_q.push_back({1'b0, cmd});
    for (int i = 0; i < len; i++) begin
      payload[i] = 8'(i * 37 + 11) ^ cmd;
      bus_q.push_back({1'b1, payload[i]});
    end
    issue(1'b0, cmd, len);
    chk(w_first == H_CMD, {tag, " R2 command byte half period"}, w_first, H_CMD);
    if (len > 64) chk(w_last == H_BULK, {tag, " R3 bulk half period"}, w_last, H_BULK);
    else if (len > 0) chk(w_last == H_CMD, {tag, " R2 short payload half period"}, w_last, H_CMD);
    end_checks(tag);
  endtask

  task automatic do_read(input logic [7:0] cmd, input int len, input bit dummy, input string tag);
    resp_dummy = dummy;
    bus_q.push_back({1'b0, cmd});
    for (int i = 0; i < len + int'(dummy); i++) bus_q.push_back(9'h000);
    for (int i = 0; i < len; i++) rd_q.push_back(resp[i]);
    issue(1'b1, cmd, len);
    chk(w_first == H_RD, {tag, " R4 read command half period"}, w_first, H_RD);
    chk(w_last == H_RD, {tag, " R4 read data half period"}, w_last, H_RD);
    end_checks(tag);
  endtask

  task automatic do_reject(input logic [7:0] cmd, input int len, input string tag);
    int f0;
    f0 = frames;
    issue(1'b1, cmd, len);
    chk(err == 1'b1, {tag, " err on rejected read"}, err, 1);
    @(negedge clk);
    chk(frames == f0, {tag, " no frame on rejected read"}, frames, f0);
    chk(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
  endtask

  task automatic pwr_read(input logic [7:0] v, input string tag);
    bit exp;
    resp[0] = v;
    exp = ((v & 8'h7C) == 8'h1C);
    do_read(8'h0A, 1, 1'b0, tag);
    chk(disp_on == exp, {tag, " R8 disp_on"}, disp_on, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cs_n == 1'b1, "R10 cs_no", cs_n, 1);
    chk(sck == 1'b0, "R10 sck_o", sck, 0);
    chk(dc == 1'b0, "R10 dc_o", dc, 0);
    chk(done == 1'b0 && err == 1'b0, "R10 done/err", {done, err}, 0);
    chk(disp_on == 1'b0, "R10 disp_on_o", disp_on, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 req_ready_o", req_ready, 1);

    do_write(8'h2A, 4, "R1 R2 w4");
    do_write(8'h29, 0, "R1 w0");
    do_write(8'h2C, 64, "R2 w64");
    do_write(8'h2C, 65, "R3 w65");

    resp[0] = 8'hC3; resp[1] = 8'h5A;
    do_read(8'h0C, 2, 1'b0, "R4 plain");
    resp[0] = 8'h81; resp[1] = 8'h7E; resp[2] = 8'hB5;
    do_read(8'h04, 3, 1'b1, "R5 id3");
    resp[0] = 8'hFF; resp[1] = 8'h01; resp[2] = 8'h80; resp[3] = 8'h69;
    do_read(8'h09, 4, 1'b1, "R5 st4");

    do_reject(8'h04, 2, "R6 id2");
    do_reject(8'h09, 5, "R6 st5");
    do_reject(8'h0C, 0, "R7 len0");
    do_reject(8'h04, 0, "R7 id0");

    pwr_read(8'h9C, "R8 active+b7");
    resp[0] = 8'h00;
    do_read(8'h0C, 1, 1'b0, "R8 other read");
    chk(disp_on == 1'b1, "R8 held over other read", disp_on, 1);
    do_write(8'h0A, 1, "R8 write same code");
    chk(disp_on == 1'b1, "R8 held over write", disp_on, 1);
    pwr_read(8'h3C, "R8 partial bit");
    pwr_read(8'h1F, "R8 active+b0b1");
    pwr_read(8'h14, "R8 no normal bit");

    finish_run();
  end
endmodule